// File: doc/BRIEF.md
# Strided Feature-Row Line Buffer

This block keeps a small set of input feature-map rows close to a vector datapath so that a row can be read many times while a convolution filter window slides over it and then moves down to the next output row. Each read returns one vector of 16 lanes of 16-bit fixed-point samples taken from one cached row, starting at a chosen column and stepping across the row with a stride of 1 to 4, so a strided convolution costs no extra cycles over a unit-stride one.

Rows are refilled in chunks of 16 samples by the memory interface while reads to the other rows go on, so loading the next row overlaps with compute. A row that is being refilled is withheld from readers until its last chunk lands. A read that cannot be served (row not ready, row written in the same cycle, or a window that runs past the row end) produces no vector; the requester keeps its request up and retries. The output vector is registered and appears one cycle after an accepted request.

Top module: `strided_row_buffer`

## Requirements
- R1: While reset is asserted and after its release, `vec_valid` is 0 and `vec_data` is all zeros, and every row is unreadable until it has been filled.
- R2: A write with `wr_chunk` = k stores element j of `wr_data` (bits [16j+15:16j]) at column 16k+j of row `wr_row`; the default row has 64 columns in 4 chunks.
- R3: A row becomes readable in the cycle after a write of its final chunk (index 3); a write of any other chunk to a row makes it unreadable from the next cycle until its final chunk is written again.
- R4: An accepted read returns in lane i (bits [16i+15:16i] of `vec_data`) the sample at column `rd_start` + i*s of row `rd_row`, where the stride s equals `rd_stride` + 1.
- R5: `vec_valid` is 1 exactly in the cycle after an accepted read request and 0 in every other cycle.
- R6: A read whose last lane column `rd_start` + 15*s exceeds 63 is not accepted; a window ending exactly at column 63 is accepted.
- R7: A read to the row written in the same cycle is not accepted; a read to a different row in a cycle with a write is accepted and the write also takes effect.
- R8: While `vec_valid` is 0, `vec_data` keeps the last vector delivered (or zeros since reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Chunk write strobe from the memory interface |
| wr_row | input | 2 | Row slot written |
| wr_chunk | input | 2 | Chunk offset within the row (final chunk = 3) |
| wr_data | input | 256 | 16 samples of 16 bits, element 0 in the low bits |
| rd_req | input | 1 | Read request, held by the requester until served |
| rd_row | input | 2 | Row slot read |
| rd_start | input | 6 | Column of lane 0 |
| rd_stride | input | 2 | Stride minus one |
| vec_valid | output | 1 | Registered vector valid |
| vec_data | output | 256 | 16 lanes of 16 bits, lane 0 in the low bits |

## Verification
The bench goes after the window that ends exactly on column 63 against one that ends on column 64; a design with an off-by-one bound check would either drop the legal read or deliver a wrapped or zero-padded lane. It reads a row mid-refill and in the same cycle its final chunk is written, where a design that updates readiness too early would hand out a mix of old and new samples. It pairs a write and a read to different rows in one cycle, which a design that serializes the two ports would stall, and it steps all four strides across chunk boundaries so a wrong lane index or chunk placement shows up as a wrong sample value.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
   // Width of an index able to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/srb_row_store.sv
`timescale 1ns/1ps
module srb_row_store
   import srb_pkg::*;
#(
   parameter int unsigned ROWS    = 4,
   parameter int unsigned ROW_LEN = 64,
   parameter int unsigned CHUNK   = 16,
   parameter int unsigned DW      = 16
) (
   input  logic                                  clk,
   input  logic                                  wr_en,
   input  logic [idx_width(ROWS)-1:0]            wr_row,
   input  logic [idx_width(ROW_LEN/CHUNK)-1:0]   wr_chunk,
   input  logic [CHUNK*DW-1:0]                   wr_data,
   input  logic [idx_width(ROWS)-1:0]            rd_row,
   output logic [ROW_LEN*DW-1:0]                 row_bits
);
   localparam int unsigned RW      = idx_width(ROWS);
   localparam int unsigned CHUNK_W = CHUNK * DW;

   logic [ROW_LEN*DW-1:0] lines [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [ROW_LEN*DW-1:0] line;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_row == RW'(r))) begin
            line[int'(wr_chunk) * CHUNK_W +: CHUNK_W] <= wr_data;
         end
      end
      assign lines[r] = line;
   end

   always_comb begin
      row_bits = lines[rd_row];
   end
endmodule

// File: rtl/srb_fill_track.sv
`timescale 1ns/1ps
module srb_fill_track
   import srb_pkg::*;
#(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned NCHUNK = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [idx_width(ROWS)-1:0]    wr_row,
   input  logic [idx_width(NCHUNK)-1:0]  wr_chunk,
   output logic [ROWS-1:0]               ready
);
   localparam int unsigned CW = idx_width(NCHUNK);
   localparam logic [CW-1:0] LAST_CHUNK = CW'(NCHUNK - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= '0;
      end else if (wr_en) begin
         ready[wr_row] <= (wr_chunk == LAST_CHUNK);
      end
   end

   // R3: the final chunk opens the row for readers
   p_final_opens_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_chunk == LAST_CHUNK) |=> ready[$past(wr_row)]);

   // R3: any earlier chunk closes the row
   p_partial_closes_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_chunk != LAST_CHUNK) |=> !ready[$past(wr_row)]);
endmodule

// File: rtl/srb_gather.sv
`timescale 1ns/1ps
module srb_gather
   import srb_pkg::*;
#(
   parameter int unsigned LANES      = 16,
   parameter int unsigned DW         = 16,
   parameter int unsigned ROW_LEN    = 64,
   parameter int unsigned MAX_STRIDE = 4
) (
   input  logic [ROW_LEN*DW-1:0]               row_bits,
   input  logic [idx_width(ROW_LEN)-1:0]       start,
   input  logic [idx_width(MAX_STRIDE)-1:0]    stride_code,
   output logic [LANES*DW-1:0]                 lanes,
   output logic                                in_bounds
);
   localparam int unsigned SPAN_MAX = ROW_LEN - 1 + (LANES - 1) * MAX_STRIDE;
   localparam int unsigned IDX_W    = idx_width(SPAN_MAX + 1);

   logic [IDX_W-1:0] step;
   logic [IDX_W-1:0] last_col;

   if (MAX_STRIDE == 1) begin : g_unit_stride
      assign step = IDX_W'(1);
   end else begin : g_var_stride
      assign step = IDX_W'(stride_code) + IDX_W'(1);
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [IDX_W-1:0] col;
      assign col = IDX_W'(start) + IDX_W'(i) * step;
      assign lanes[i*DW +: DW] = (col < IDX_W'(ROW_LEN)) ?
                                 row_bits[int'(col)*DW +: DW] : '0;
   end

   assign last_col  = IDX_W'(start) + IDX_W'(LANES - 1) * step;
   assign in_bounds = (last_col < IDX_W'(ROW_LEN));
endmodule

// File: rtl/strided_row_buffer.sv
`timescale 1ns/1ps
module strided_row_buffer
   import srb_pkg::*;
#(
   parameter int unsigned ROWS       = 4,
   parameter int unsigned ROW_LEN    = 64,
   parameter int unsigned CHUNK      = 16,
   parameter int unsigned LANES      = 16,
   parameter int unsigned DW         = 16,
   parameter int unsigned MAX_STRIDE = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_valid,
   input  logic [idx_width(ROWS)-1:0]            wr_row,
   input  logic [idx_width(ROW_LEN/CHUNK)-1:0]   wr_chunk,
   input  logic [CHUNK*DW-1:0]                   wr_data,
   input  logic                                  rd_req,
   input  logic [idx_width(ROWS)-1:0]            rd_row,
   input  logic [idx_width(ROW_LEN)-1:0]         rd_start,
   input  logic [idx_width(MAX_STRIDE)-1:0]      rd_stride,
   output logic                                  vec_valid,
   output logic [LANES*DW-1:0]                   vec_data
);
   localparam int unsigned NCHUNK = ROW_LEN / CHUNK;

   initial begin
      a_chunk_divides: assert (ROW_LEN % CHUNK == 0)
         else $error("row length must be a whole number of chunks");
      a_lanes_fit: assert (LANES <= ROW_LEN)
         else $error("vector wider than a row");
      a_stride_pow2: assert (is_pow2(MAX_STRIDE))
         else $error("maximum stride must be a power of two");
      a_rows: assert (ROWS >= 2)
         else $error("at least two rows are needed to overlap refill");
   end

   logic [ROW_LEN*DW-1:0] row_bits;
   logic [ROWS-1:0]       row_ready;
   logic [LANES*DW-1:0]   gathered;
   logic                  in_bounds;
   logic                  row_busy;
   logic                  accept;

   srb_row_store #(
      .ROWS(ROWS), .ROW_LEN(ROW_LEN), .CHUNK(CHUNK), .DW(DW)
   ) u_store (
      .clk(clk), .wr_en(wr_valid), .wr_row(wr_row), .wr_chunk(wr_chunk),
      .wr_data(wr_data), .rd_row(rd_row), .row_bits(row_bits)
   );

   srb_fill_track #(
      .ROWS(ROWS), .NCHUNK(NCHUNK)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_valid), .wr_row(wr_row),
      .wr_chunk(wr_chunk), .ready(row_ready)
   );

   srb_gather #(
      .LANES(LANES), .DW(DW), .ROW_LEN(ROW_LEN), .MAX_STRIDE(MAX_STRIDE)
   ) u_gather (
      .row_bits(row_bits), .start(rd_start), .stride_code(rd_stride),
      .lanes(gathered), .in_bounds(in_bounds)
   );

   assign row_busy = wr_valid && (wr_row == rd_row);
   assign accept   = rd_req && row_ready[rd_row] && in_bounds && !row_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_data  <= '0;
      end else begin
         vec_valid <= accept;
         if (accept) begin
            vec_data <= gathered;
         end
      end
   end

   // R5: no vector without a request one cycle earlier
   p_valid_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(rd_req));

   // R3: a row that is not filled yields nothing
   p_unready_row_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !row_ready[rd_row]) |=> !vec_valid);

   // R6: windows past the row end yield nothing
   p_out_of_row_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !in_bounds) |=> !vec_valid);

   // R7: same-row write blocks the read
   p_same_row_write_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && wr_valid && wr_row == rd_row) |=> !vec_valid);

   // R8: output vector held while not valid
   p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> $stable(vec_data));
endmodule

// File: tb/strided_row_buffer_test.sv
`timescale 1ns/1ps
module strided_row_buffer_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [1:0]   wr_row = '0;
   logic [1:0]   wr_chunk = '0;
   logic [255:0] wr_data = '0;
   logic         rd_req = 1'b0;
   logic [1:0]   rd_row = '0;
   logic [5:0]   rd_start = '0;
   logic [1:0]   rd_stride = '0;
   logic         vec_valid;
   logic [255:0] vec_data;

   always #2.5 clk = ~clk;

   strided_row_buffer uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_row(wr_row),
      .wr_chunk(wr_chunk), .wr_data(wr_data), .rd_req(rd_req), .rd_row(rd_row),
      .rd_start(rd_start), .rd_stride(rd_stride), .vec_valid(vec_valid),
      .vec_data(vec_data)
   );

   typedef struct {
      bit           v;
      logic [255:0] d;
      string        tag;
   } item_t;

   item_t        sb[$];
   int           checks = 0;
   int           failures = 0;
   logic [15:0]  model [4][64];
   bit           model_rdy [4];
   logic [255:0] last_vec = '0;
   bit           finished = 1'b0;

   function automatic logic [15:0] sample(int gen, int row, int col);
      return 16'((gen << 8) | (row << 6) | col);
   endfunction

   // Driver: one call per cycle, pushes the expected output of the next edge.
   task automatic step(input bit wv, input int wrow, input int wchk, input int wgen,
                       input bit rv, input int rrow, input int rstart, input int rcode,
                       input string tag);
      item_t it;
      int    s;
      bit    acc;
      @(negedge clk);
      wr_valid  = wv;
      wr_row    = 2'(wrow);
      wr_chunk  = 2'(wchk);
      for (int j = 0; j < 16; j++) wr_data[j*16 +: 16] = sample(wgen, wrow, wchk*16 + j);
      rd_req    = rv;
      rd_row    = 2'(rrow);
      rd_start  = 6'(rstart);
      rd_stride = 2'(rcode);
      s   = rcode + 1;
      acc = rst_n && rv && model_rdy[rrow] && (rstart + 15*s <= 63) && !(wv && wrow == rrow);
      if (acc) begin
         for (int i = 0; i < 16; i++) last_vec[i*16 +: 16] = model[rrow][rstart + i*s];
      end
      if (!rst_n) last_vec = '0;
      it.v = acc;
      it.d = last_vec;
      it.tag = tag;
      sb.push_back(it);
      if (wv && rst_n) begin
         for (int j = 0; j < 16; j++) model[wrow][wchk*16 + j] = sample(wgen, wrow, wchk*16 + j);
         model_rdy[wrow] = (wchk == 3);
      end
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic fill_row(input int row, input int gen, input string tag);
      for (int k = 0; k < 4; k++) step(1, row, k, gen, 0, 0, 0, 0, tag);
   endtask

   // Monitor: compares each produced cycle against the queued expectation.
   always @(posedge clk) begin
      #1;
      if (sb.size() != 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (vec_valid !== it.v || vec_data !== it.d) begin
            failures++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     it.tag, vec_valid, vec_data, it.v, it.d);
         end
      end
   end

   initial begin
      for (int r = 0; r < 4; r++) begin
         model_rdy[r] = 1'b0;
         for (int c = 0; c < 64; c++) model[r][c] = '0;
      end
      // R1: reset state
      idle("R1 reset");
      idle("R1 reset");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R1 read during reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 0, 1, 2, 0, 0, "R1 read of empty row after reset");
      // R2/R3: partial fill is not readable
      step(1, 0, 0, 1, 0, 0, 0, 0, "R2 chunk write");
      step(1, 0, 1, 1, 1, 0, 0, 0, "R3 read while filling");
      step(1, 0, 2, 1, 1, 0, 0, 0, "R3 read while filling");
      step(1, 0, 3, 1, 0, 0, 0, 0, "R3 final chunk");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R4 unit stride start 0");
      idle("R8 hold after vector");
      idle("R8 hold after vector");
      step(0, 0, 0, 0, 1, 0, 5, 1, "R4 stride 2");
      step(0, 0, 0, 0, 1, 0, 7, 2, "R4 stride 3");
      step(0, 0, 0, 0, 1, 0, 3, 3, "R6 stride 4 ending at column 63");
      step(0, 0, 0, 0, 1, 0, 4, 3, "R6 stride 4 ending at column 64");
      step(0, 0, 0, 0, 1, 0, 48, 0, "R6 unit stride ending at 63");
      step(0, 0, 0, 0, 1, 0, 49, 0, "R6 unit stride past end");
      step(0, 0, 0, 0, 1, 0, 34, 1, "R6 stride 2 past end");
      idle("R8 hold");
      // fill the other rows
      fill_row(1, 2, "R2 fill row 1");
      fill_row(2, 3, "R2 fill row 2");
      fill_row(3, 4, "R2 fill row 3");
      step(0, 0, 0, 0, 1, 3, 2, 3, "R4 row 3 stride 4");
      step(0, 0, 0, 0, 1, 1, 10, 0, "R5 back-to-back read");
      step(0, 0, 0, 0, 1, 2, 1, 2, "R5 back-to-back read");
      // R7: concurrent write and read to different rows
      step(1, 2, 0, 5, 1, 1, 17, 1, "R7 read row 1 while refilling row 2");
      step(1, 2, 1, 5, 1, 2, 0, 0, "R3 read of row under refill");
      step(1, 2, 2, 5, 1, 3, 0, 3, "R7 read row 3 during refill");
      step(1, 2, 3, 5, 1, 2, 0, 0, "R7 read of row getting final chunk");
      step(0, 0, 0, 0, 1, 2, 0, 0, "R3 refilled row readable");
      step(0, 0, 0, 0, 1, 2, 15, 2, "R2 new row contents stride 3");
      // R3: refill row 0 with reads held on it
      step(1, 0, 0, 6, 1, 0, 0, 0, "R7 read of row getting first chunk");
      step(1, 0, 1, 6, 1, 0, 0, 0, "R3 read of row under refill");
      step(1, 0, 2, 6, 0, 0, 0, 0, "R3 refill");
      step(1, 0, 3, 6, 1, 1, 0, 3, "R7 read row 1 with final chunk to row 0");
      step(0, 0, 0, 0, 1, 0, 3, 3, "R4 refilled row 0 stride 4");
      idle("R8 hold");
      idle("R8 hold");
      idle("R5 drain");
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule